// File: doc/BRIEF.md
# Multi-bank cartridge header detector

This block decides whether an attached cartridge ROM is a two-bank multi-pack. When started, it reads a handful of fixed header bytes one at a time through a request/response port that feeds a ROM bus master. It does not generate bus timing itself. From the values it reads, it reports whether the cartridge is a multi-pack, the two bank-select values, the total ROM size in bytes, and a warning when the bank pair is not one of the recognised combinations.

Probing follows a fixed order and stops as soon as the outcome is settled. The bank-0 selector at 0x3FFC is read first, then the bank-1 selector at 0x3FFD, then the guard byte at 0x3FFB, and finally the guard byte at 0x3FFF. Both selectors must be nonzero and both guards must be zero. The size is then looked up from the selector pair.

A one-cycle `done` pulse marks the end of a probe. The results hold until the next accepted `start`.

Top module: `mbank_probe`

## Requirements
- R1: A `start` accepted while idle clears `is_multi`, `bank_lo`, `bank_hi`, `rom_size` and `size_warn` to zero on the next clock edge.
- R2: `req_valid` stays high, with `req_addr` unchanged, until a cycle in which `req_ready` is high. Only one read is outstanding at a time. The returned byte is used only in a cycle where `rsp_valid` is high.
- R3: The first read goes to address 0x3FFC. If that byte is zero, the probe ends after this single read, with `is_multi` low and both bank values zero.
- R4: If byte 0x3FFD is zero, the probe ends after two reads with `is_multi` low. `bank_lo` keeps the nonzero value read from 0x3FFC and `bank_hi` stays zero.
- R5: The guard bytes are read in the order 0x3FFB, then 0x3FFF, and both must be zero for `is_multi` to be set. A nonzero 0x3FFB ends the probe after three reads, without reading 0x3FFF. Both bank values stay as read.
- R6: A confirmed pair with bank_lo = 0x28 and bank_hi = 0x2E gives `rom_size` = 0x200000 with `size_warn` low.
- R7: A confirmed pair with bank_lo = 0x20 and bank_hi = 0x31 gives `rom_size` = 0x400000 with `size_warn` low.
- R8: Any other confirmed pair of nonzero values gives `rom_size` = 0x400000 with `size_warn` high.
- R9: `done` is high for exactly one cycle per probe. When `is_multi` is low, `rom_size` and `size_warn` are zero. All results hold unchanged while the block is idle and `start` is low.
- R10: A `start` that arrives while a probe is in progress is ignored. The probe runs to completion without restarting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a probe (accepted only while idle) |
| req_valid | output | 1 | Read request pending |
| req_ready | input | 1 | Bus master accepts the pending request |
| req_addr | output | ADDR_W | Byte address of the pending read |
| rsp_valid | input | 1 | Read data is valid this cycle |
| rsp_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle end-of-probe pulse |
| is_multi | output | 1 | Cartridge identified as two-bank multi-pack |
| bank_lo | output | 8 | Value that selects bank 0 |
| bank_hi | output | 8 | Value that selects bank 1 |
| rom_size | output | SIZE_W | Inferred total size in bytes (zero if not multi-pack) |
| size_warn | output | 1 | Selector pair not recognised; size defaulted to 4 MiB |

## Verification
The hardest case to reach is a `start` arriving in the middle of a probe. That restart must be ignored and must not bring the sequence back to the first header address. The bench stretches both the request acceptance and the response latency of its ROM model so that a probe spans many cycles. It then pulses `start` a few cycles in and counts the reads and their addresses. The early-exit paths also need dedicated header images: a nonzero 0x3FFB, for example, must be shown to skip the final read. To get there, the bench places zeros and nonzero bytes at chosen header positions and checks the read log as well as the results.

// File: rtl/mbank_pkg.sv
`timescale 1ns/1ps
package mbank_pkg;

    localparam int BYTE_W     = 8;
    localparam int HDR_ADDR_W = 16;

    // Header probe locations (order is behaviour)
    localparam logic [HDR_ADDR_W-1:0] LOC_SEL_LO = 16'h3FFC;
    localparam logic [HDR_ADDR_W-1:0] LOC_SEL_HI = 16'h3FFD;
    localparam logic [HDR_ADDR_W-1:0] LOC_GUARD0 = 16'h3FFB;
    localparam logic [HDR_ADDR_W-1:0] LOC_GUARD1 = 16'h3FFF;

    // Recognised selector pairs
    localparam logic [BYTE_W-1:0] PAIR2M_LO = 8'h28;
    localparam logic [BYTE_W-1:0] PAIR2M_HI = 8'h2E;
    localparam logic [BYTE_W-1:0] PAIR4M_LO = 8'h20;
    localparam logic [BYTE_W-1:0] PAIR4M_HI = 8'h31;

    localparam int LOG2_2MIB = 21;
    localparam int LOG2_4MIB = 22;

    typedef enum logic [1:0] {
        PR_SEL_LO,
        PR_SEL_HI,
        PR_GUARD0,
        PR_GUARD1
    } probe_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_FINISH
    } seq_e;

    typedef enum logic [1:0] {
        SZ_NONE,
        SZ_2MIB,
        SZ_4MIB
    } size_e;

    typedef struct packed {
        logic              clear;
        logic              take_lo;
        logic              take_hi;
        logic              confirm;
        logic [BYTE_W-1:0] data;
    } evt_t;

    typedef struct packed {
        size_e kind;
        logic  warn;
    } verdict_t;

    function automatic logic [HDR_ADDR_W-1:0] probe_loc(input probe_e p);
        logic [HDR_ADDR_W-1:0] a;
        case (p)
            PR_SEL_LO: a = LOC_SEL_LO;
            PR_SEL_HI: a = LOC_SEL_HI;
            PR_GUARD0: a = LOC_GUARD0;
            PR_GUARD1: a = LOC_GUARD1;
            default:   a = LOC_SEL_LO;
        endcase
        return a;
    endfunction

    function automatic verdict_t classify(input logic [BYTE_W-1:0] lo,
                                          input logic [BYTE_W-1:0] hi);
        verdict_t v;
        v.kind = SZ_4MIB;
        v.warn = 1'b1;
        if (lo == PAIR2M_LO && hi == PAIR2M_HI) begin
            v.kind = SZ_2MIB;
            v.warn = 1'b0;
        end else if (lo == PAIR4M_LO && hi == PAIR4M_HI) begin
            v.kind = SZ_4MIB;
            v.warn = 1'b0;
        end
        return v;
    endfunction

endpackage

// File: rtl/mbank_seq.sv
`timescale 1ns/1ps
module mbank_seq
    import mbank_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [BYTE_W-1:0] rsp_data,
    output logic              done,
    output logic              busy,
    output evt_t              evt
);

    seq_e   state;
    probe_e step;
    logic   byte_zero;
    logic   got;

    assign byte_zero = (rsp_data == '0);
    assign got       = (state == ST_AWAIT) && rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= PR_SEL_LO;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_ISSUE;
                        step  <= PR_SEL_LO;
                    end
                end
                ST_ISSUE: begin
                    if (req_ready) state <= ST_AWAIT;
                end
                ST_AWAIT: begin
                    if (rsp_valid) begin
                        case (step)
                            PR_SEL_LO: begin
                                if (byte_zero) state <= ST_FINISH;
                                else begin
                                    step  <= PR_SEL_HI;
                                    state <= ST_ISSUE;
                                end
                            end
                            PR_SEL_HI: begin
                                if (byte_zero) state <= ST_FINISH;
                                else begin
                                    step  <= PR_GUARD0;
                                    state <= ST_ISSUE;
                                end
                            end
                            PR_GUARD0: begin
                                if (!byte_zero) state <= ST_FINISH;
                                else begin
                                    step  <= PR_GUARD1;
                                    state <= ST_ISSUE;
                                end
                            end
                            default: state <= ST_FINISH;
                        endcase
                    end
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_valid   = (state == ST_ISSUE);
        req_addr    = ADDR_W'(probe_loc(step));
        done        = (state == ST_FINISH);
        busy        = (state != ST_IDLE);
        evt.clear   = (state == ST_IDLE) && start;
        evt.take_lo = got && (step == PR_SEL_LO) && !byte_zero;
        evt.take_hi = got && (step == PR_SEL_HI) && !byte_zero;
        evt.confirm = got && (step == PR_GUARD1) && byte_zero;
        evt.data    = rsp_data;
    end

endmodule

// File: rtl/mbank_result.sv
`timescale 1ns/1ps
module mbank_result
    import mbank_pkg::*;
#(
    parameter int SIZE_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_t              evt,
    output logic              is_multi,
    output logic [BYTE_W-1:0] bank_lo,
    output logic [BYTE_W-1:0] bank_hi,
    output logic [SIZE_W-1:0] rom_size,
    output logic              size_warn
);

    localparam logic [SIZE_W-1:0] BYTES_2MIB = SIZE_W'(1) << LOG2_2MIB;
    localparam logic [SIZE_W-1:0] BYTES_4MIB = SIZE_W'(1) << LOG2_4MIB;

    verdict_t verdict;

    assign verdict = classify(bank_lo, bank_hi);

    always_ff @(posedge clk) begin
        if (rst || evt.clear) begin
            is_multi  <= 1'b0;
            bank_lo   <= '0;
            bank_hi   <= '0;
            rom_size  <= '0;
            size_warn <= 1'b0;
        end else begin
            if (evt.take_lo) bank_lo <= evt.data;
            if (evt.take_hi) bank_hi <= evt.data;
            if (evt.confirm) begin
                is_multi  <= 1'b1;
                size_warn <= verdict.warn;
                case (verdict.kind)
                    SZ_2MIB: rom_size <= BYTES_2MIB;
                    SZ_4MIB: rom_size <= BYTES_4MIB;
                    default: rom_size <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/mbank_probe.sv
`timescale 1ns/1ps
module mbank_probe
    import mbank_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int SIZE_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    output logic              done,
    output logic              is_multi,
    output logic [7:0]        bank_lo,
    output logic [7:0]        bank_hi,
    output logic [SIZE_W-1:0] rom_size,
    output logic              size_warn
);

    evt_t seq_evt;
    logic seq_busy;

    mbank_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .done      (done),
        .busy      (seq_busy),
        .evt       (seq_evt)
    );

    mbank_result #(.SIZE_W(SIZE_W)) u_res (
        .clk       (clk),
        .rst       (rst),
        .evt       (seq_evt),
        .is_multi  (is_multi),
        .bank_lo   (bank_lo),
        .bank_hi   (bank_hi),
        .rom_size  (rom_size),
        .size_warn (size_warn)
    );

endmodule

// File: rtl/mbank_probe_chk.sv
`timescale 1ns/1ps
module mbank_probe_chk #(
    parameter int ADDR_W = 22,
    parameter int SIZE_W = 23
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              done,
    input logic              is_multi,
    input logic [7:0]        bank_lo,
    input logic [7:0]        bank_hi,
    input logic [SIZE_W-1:0] rom_size,
    input logic              size_warn
);

    localparam logic [SIZE_W-1:0] SZ2 = SIZE_W'(1) << 21;
    localparam logic [SIZE_W-1:0] SZ4 = SIZE_W'(1) << 22;

    // R1
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> !is_multi && bank_lo == 8'h00 && bank_hi == 8'h00
                           && rom_size == '0 && !size_warn);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    // R3
    multi_banks_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        is_multi |-> bank_lo != 8'h00 && bank_hi != 8'h00);

    // R6
    multi_size_legal_chk: assert property (@(posedge clk) disable iff (rst)
        is_multi |-> rom_size == SZ2 || rom_size == SZ4);

    // R8
    warn_means_4m_chk: assert property (@(posedge clk) disable iff (rst)
        size_warn |-> is_multi && rom_size == SZ4);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    single_zero_size_chk: assert property (@(posedge clk) disable iff (rst)
        !is_multi |-> rom_size == '0 && !size_warn);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> $stable(is_multi) && $stable(bank_lo)
                            && $stable(bank_hi) && $stable(rom_size)
                            && $stable(size_warn));

    // R10
    busy_no_done_restart_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy);

endmodule

bind mbank_probe mbank_probe_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (seq_busy),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .done      (done),
    .is_multi  (is_multi),
    .bank_lo   (bank_lo),
    .bank_hi   (bank_hi),
    .rom_size  (rom_size),
    .size_warn (size_warn)
);

// File: tb/test_mbank_probe.sv
`timescale 1ns/1ps
module test_mbank_probe;

    localparam int ADDR_W = 22;
    localparam int SIZE_W = 23;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic              rsp_valid;
    logic [7:0]        rsp_data;
    logic              done;
    logic              is_multi;
    logic [7:0]        bank_lo;
    logic [7:0]        bank_hi;
    logic [SIZE_W-1:0] rom_size;
    logic              size_warn;

    int checks = 0;
    int errors = 0;

    // ROM model header image and latencies
    logic [7:0] h_fb, h_fc, h_fd, h_ff;
    int ready_lat = 0;
    int rsp_lat   = 0;
    int rd_cnt    = 0;
    logic [15:0] rd_log [0:7];

    always #2.5 clk = ~clk;

    mbank_probe #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_mbank_probe (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .done      (done),
        .is_multi  (is_multi),
        .bank_lo   (bank_lo),
        .bank_hi   (bank_hi),
        .rom_size  (rom_size),
        .size_warn (size_warn)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] hdr(input logic [15:0] a);
        case (a)
            16'h3FFB: return h_fb;
            16'h3FFC: return h_fc;
            16'h3FFD: return h_fd;
            16'h3FFF: return h_ff;
            default:  return 8'h5A;
        endcase
    endfunction

    // ROM responder
    initial begin
        logic [15:0] a0;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = 8'h00;
        forever begin
            @(negedge clk);
            if (req_valid) begin
                a0 = req_addr[15:0];
                repeat (ready_lat) begin
                    @(negedge clk);
                    chk("R2 request held", {31'd0, req_valid}, 32'd1);
                    chk("R2 address stable", {16'd0, req_addr[15:0]}, {16'd0, a0});
                end
                req_ready = 1'b1;
                rd_log[rd_cnt % 8] = a0;
                rd_cnt++;
                @(negedge clk);
                req_ready = 1'b0;
                repeat (rsp_lat) begin
                    // garbage on the data lines while not valid (R2)
                    rsp_data = 8'hFF;
                    @(negedge clk);
                end
                rsp_data  = hdr(a0);
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_data  = 8'h00;
            end
        end
    end

    task automatic show_summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        show_summary();
        $finish;
    end

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " done seen"}, {31'd0, done}, 32'd1);
    endtask

    task automatic run_probe(input logic [7:0] fc, input logic [7:0] fd,
                             input logic [7:0] fb, input logic [7:0] ff,
                             input int rl, input int dl, input bit mid_start);
        h_fc = fc; h_fd = fd; h_fb = fb; h_ff = ff;
        ready_lat = rl; rsp_lat = dl;
        rd_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1: results cleared right after the accepting edge
        chk("R1 multi cleared", {31'd0, is_multi}, 32'd0);
        chk("R1 bank_lo cleared", {24'd0, bank_lo}, 32'd0);
        chk("R1 bank_hi cleared", {24'd0, bank_hi}, 32'd0);
        chk("R1 size cleared", {9'd0, rom_size}, 32'd0);
        chk("R1 warn cleared", {31'd0, size_warn}, 32'd0);
        if (mid_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done("probe");
    endtask

    task automatic check_result(input string tag, input int reads, input logic m,
                                input logic [7:0] lo, input logic [7:0] hi,
                                input logic [31:0] sz, input logic w);
        chk({tag, " read count"}, reads, rd_cnt);
        chk({tag, " multi"}, {31'd0, is_multi}, {31'd0, m});
        chk({tag, " bank_lo"}, {24'd0, bank_lo}, {24'd0, lo});
        chk({tag, " bank_hi"}, {24'd0, bank_hi}, {24'd0, hi});
        chk({tag, " size"}, {9'd0, rom_size}, sz);
        chk({tag, " warn"}, {31'd0, size_warn}, {31'd0, w});
    endtask

    task automatic t_reset();
        chk("R9 reset done", {31'd0, done}, 32'd0);
        chk("R2 reset req_valid", {31'd0, req_valid}, 32'd0);
        check_result("R9 reset", 0, 1'b0, 8'h00, 8'h00, 32'h0, 1'b0);
    endtask

    task automatic t_pair_2m();
        run_probe(8'h28, 8'h2E, 8'h00, 8'h00, 0, 0, 1'b0);
        check_result("R6 2MiB pair", 4, 1'b1, 8'h28, 8'h2E, 32'h200000, 1'b0);
        chk("R3 first addr", {16'd0, rd_log[0]}, 32'h3FFC);
        chk("R4 second addr", {16'd0, rd_log[1]}, 32'h3FFD);
        chk("R5 third addr", {16'd0, rd_log[2]}, 32'h3FFB);
        chk("R5 fourth addr", {16'd0, rd_log[3]}, 32'h3FFF);
        @(negedge clk);
        chk("R9 done one cycle", {31'd0, done}, 32'd0);
        repeat (5) @(negedge clk);
        check_result("R9 hold", 4, 1'b1, 8'h28, 8'h2E, 32'h200000, 1'b0);
    endtask

    task automatic t_pair_4m();
        run_probe(8'h20, 8'h31, 8'h00, 8'h00, 2, 3, 1'b0);
        check_result("R7 4MiB pair", 4, 1'b1, 8'h20, 8'h31, 32'h400000, 1'b0);
    endtask

    task automatic t_pair_unknown();
        run_probe(8'h11, 8'h22, 8'h00, 8'h00, 1, 0, 1'b0);
        check_result("R8 unknown pair", 4, 1'b1, 8'h11, 8'h22, 32'h400000, 1'b1);
    endtask

    task automatic t_sel_lo_zero();
        run_probe(8'h00, 8'h2E, 8'h00, 8'h00, 0, 1, 1'b0);
        check_result("R3 lo zero", 1, 1'b0, 8'h00, 8'h00, 32'h0, 1'b0);
        chk("R3 only addr", {16'd0, rd_log[0]}, 32'h3FFC);
    endtask

    task automatic t_sel_hi_zero();
        run_probe(8'h28, 8'h00, 8'h00, 8'h00, 0, 0, 1'b0);
        check_result("R4 hi zero", 2, 1'b0, 8'h28, 8'h00, 32'h0, 1'b0);
    endtask

    task automatic t_guard0_set();
        run_probe(8'h28, 8'h2E, 8'h07, 8'h00, 0, 0, 1'b0);
        check_result("R5 guard0 set", 3, 1'b0, 8'h28, 8'h2E, 32'h0, 1'b0);
    endtask

    task automatic t_guard1_set();
        run_probe(8'h20, 8'h31, 8'h00, 8'h80, 0, 2, 1'b0);
        check_result("R5 guard1 set", 4, 1'b0, 8'h20, 8'h31, 32'h0, 1'b0);
    endtask

    task automatic t_start_busy();
        run_probe(8'h20, 8'h31, 8'h00, 8'h00, 3, 3, 1'b1);
        check_result("R10 start ignored", 4, 1'b1, 8'h20, 8'h31, 32'h400000, 1'b0);
        chk("R10 second addr", {16'd0, rd_log[1]}, 32'h3FFD);
    endtask

    initial begin
        rst   = 1'b1;
        start = 1'b0;
        h_fb = 8'h00; h_fc = 8'h00; h_fd = 8'h00; h_ff = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pair_2m();
        t_pair_4m();
        t_pair_unknown();
        t_sel_lo_zero();
        t_pair_2m();
        t_sel_hi_zero();
        t_guard0_set();
        t_guard1_set();
        t_start_busy();
        repeat (3) @(negedge clk);
        show_summary();
        $finish;
    end

endmodule